// File: doc/BRIEF.md
# Post-Register Parity Checked Datapath

This block is a small datapath protected by concurrent error detection. A combinational function mixes two W-bit operands (bitwise XOR, then a fixed left rotation by ROT places) into a W-bit result. In parallel, a predictor forms the expected parity bit of that result from the operands alone, as the XOR of the two operand parities. The result and the predicted bit are each captured in their own register on the same clock edge.

Checking happens only after that register boundary. The registered result is re-encoded into a parity bit, and that bit is compared with the registered prediction. Because both inputs to the comparison are stable for the whole cycle, a late transient on the logic output cannot corrupt the stored data and also stay hidden from the flag. The combinational flag is valid throughout the cycle that follows a capture. A sticky copy holds any detected error until reset.

Three verification-only controls can flip one chosen bit in three places: on the logic output just before capture, in the captured data word, or in the captured prediction bit. Each of these is a single upset that the flag must report.

Top module: `pchk_top`

## Requirements
- R1: After reset, q_data is all zeros, err_now is 0 and err_sticky is 0.
- R2: On each rising clock edge, q_data captures rotl(a ^ b, ROT): bit i of the result is (a^b)[(i - ROT) mod W].
- R3: With no injection active, err_now is 0 in every cycle.
- R4: err_now is 1 exactly when the parity (XOR of all bits) of q_data differs from the registered prediction, which is the parity of a XOR the parity of b from the same capture edge.
- R5: When inj_logic is 1 at a capture edge, bit inj_idx of the logic output is inverted before capture, so q_data differs from the correct value in that one bit and err_now is 1 in the next cycle.
- R6: When inj_data is 1 at a capture edge, bit inj_idx of the word written into the data register is inverted, and err_now is 1 in the next cycle.
- R7: When inj_pred is 1 at a capture edge, the bit written into the prediction register is inverted, and err_now is 1 in the next cycle while q_data still holds the correct value.
- R8: err_sticky becomes 1 on the edge after any cycle in which err_now is 1, and stays 1 until reset.
- R9: No single injection leaves q_data wrong while err_now reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a | input | W | First operand |
| b | input | W | Second operand |
| inj_logic | input | 1 | Flip one bit of the logic output before capture (verification) |
| inj_data | input | 1 | Flip one bit of the captured data word (verification) |
| inj_pred | input | 1 | Flip the captured prediction bit (verification) |
| inj_idx | input | IW | Bit index used by inj_logic and inj_data |
| q_data | output | W | Registered result |
| err_now | output | 1 | Combinational mismatch flag from the registers |
| err_sticky | output | 1 | Error flag held until reset |

## Verification
The bench builds the block with W = 8 and ROT = 3. With these values every bit position can be flipped in a short run, and the rotation moves operand bits across the word boundary, so a wrong index mapping shows up in q_data. The reference model forms each expected word with integer shifts rather than a rotate function. It also sweeps all 8 indices for both data-path injection points.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  function automatic logic par_of(input logic [63:0] v, input int unsigned n);
    logic p;
    p = 1'b0;
    for (int unsigned i = 0; i < n; i++) p = p ^ v[i];
    return p;
  endfunction
endpackage

// File: rtl/pchk_logic.sv
module pchk_logic #(
  parameter int W   = 8,
  parameter int ROT = 3,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          flip,
  input  logic [IW-1:0] idx,
  output logic [W-1:0]  y
);
  localparam int RR = ROT % W;
  logic [W-1:0] mix, rot;
  assign mix = a ^ b;
  generate
    for (genvar i = 0; i < W; i++) begin : g_rot
      assign rot[i] = mix[(i - RR + W) % W];
    end
  endgenerate
  always_comb begin
    y = rot;
    if (flip) y[idx] = ~rot[idx];
  end
endmodule

// File: rtl/pchk_pred.sv
module pchk_pred #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         p
);
  import pchk_pkg::*;
  assign p = par_of(64'(a), W) ^ par_of(64'(b), W);
endmodule

// File: rtl/pchk_check.sv
module pchk_check #(
  parameter int W = 8
) (
  input  logic [W-1:0] d,
  input  logic         p,
  output logic         mismatch
);
  import pchk_pkg::*;
  logic enc;
  assign enc = par_of(64'(d), W);
  assign mismatch = enc ^ p;
endmodule

// File: rtl/pchk_top.sv
module pchk_top #(
  parameter int W   = 8,
  parameter int ROT = 3,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          inj_logic,
  input  logic          inj_data,
  input  logic          inj_pred,
  input  logic [IW-1:0] inj_idx,
  output logic [W-1:0]  q_data,
  output logic          err_now,
  output logic          err_sticky
);
  logic [W-1:0] logic_y, d_next, data_q;
  logic         pred_c, pred_next, pred_q, mismatch;

  pchk_logic #(.W(W), .ROT(ROT)) u_logic (
    .a(a), .b(b), .flip(inj_logic), .idx(inj_idx), .y(logic_y));

  pchk_pred #(.W(W)) u_pred (.a(a), .b(b), .p(pred_c));

  always_comb begin
    d_next = logic_y;
    if (inj_data) d_next[inj_idx] = ~logic_y[inj_idx];
    pred_next = pred_c ^ inj_pred;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      pred_q <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      data_q <= d_next;
      pred_q <= pred_next;
      if (mismatch) err_sticky <= 1'b1;
    end
  end

  pchk_check #(.W(W)) u_chk (.d(data_q), .p(pred_q), .mismatch(mismatch));

  assign q_data  = data_q;
  assign err_now = mismatch;

  // R3: with no injection, the next cycle carries no flag
  p_clean_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_logic && !inj_data && !inj_pred) |=> !err_now);
  // R7: a flipped prediction is always reported
  p_pred_flip_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_pred && !inj_logic && !inj_data) |=> err_now);
  // R6: a single flipped data bit is reported
  p_data_flip_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_data && !inj_logic && !inj_pred) |=> err_now);
  // R5: a single flipped logic output bit is reported
  p_logic_flip_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_logic && !inj_data && !inj_pred) |=> err_now);
  // R8: sticky flag follows a mismatch and then holds
  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_now |=> err_sticky);
  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

// File: tb/test_pchk_top.sv
module test_pchk_top;
  localparam int W = 8;
  localparam int ROT = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic [W-1:0] a, b;
  logic inj_logic, inj_data, inj_pred;
  logic [2:0] inj_idx;
  logic [W-1:0] q_data;
  logic err_now, err_sticky;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  pchk_top #(.W(W), .ROT(ROT)) i_pchk_top (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b),
    .inj_logic(inj_logic), .inj_data(inj_data), .inj_pred(inj_pred),
    .inj_idx(inj_idx), .q_data(q_data), .err_now(err_now),
    .err_sticky(err_sticky));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int ref_word(input int x, input int y);
    int m;
    m = (x ^ y) & 255;
    return ((m * (1 << ROT)) | (m / (1 << (W - ROT)))) & 255;
  endfunction

  function automatic int ones(input int v);
    int c = 0;
    for (int k = 0; k < W; k++) if (((v / (1 << k)) % 2) == 1) c++;
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply one vector at negedge, step over posedge, sample at next negedge
  task automatic step(input int x, input int y, input bit il, input bit id,
                      input bit ip, input int ix, input string req);
    int exp_w;
    bit exp_e;
    a = x[W-1:0]; b = y[W-1:0];
    inj_logic = il; inj_data = id; inj_pred = ip; inj_idx = ix[2:0];
    @(negedge clk);
    exp_w = ref_word(x, y);
    if (il) exp_w = exp_w ^ (1 << ix);
    if (id) exp_w = exp_w ^ (1 << ix);
    exp_e = ((ones(exp_w) + ones(x & 255) + ones(y & 255) + int'(ip)) % 2) == 1;
    chk({req, " data"}, int'(q_data), exp_w);
    chk({req, " flag"}, int'(err_now), int'(exp_e));
    if ((exp_w != ref_word(x, y)) && !err_now) begin
      fails++;
      $display("FAIL R9 silent corruption actual=%0h expected=%0h", q_data, ref_word(x, y));
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; a = 8'hA5; b = 8'h3C;
    inj_logic = 0; inj_data = 0; inj_pred = 0; inj_idx = 0;
    repeat (2) @(negedge clk);
    chk("R1 data", int'(q_data), 0);
    chk("R1 flag", int'(err_now), 0);
    chk("R1 sticky", int'(err_sticky), 0);
    rst_n = 1'b1;
    // R2, R3, R4: clean patterns
    step(8'h01, 8'h00, 0, 0, 0, 0, "R2");
    step(8'h80, 8'h00, 0, 0, 0, 0, "R2 wrap");
    step(8'hFF, 8'h0F, 0, 0, 0, 0, "R3");
    step(8'h5A, 8'hC3, 0, 0, 0, 0, "R4");
    for (int k = 0; k < 20; k++)
      step((k * 37 + 11) & 255, (k * 91 + 5) & 255, 0, 0, 0, 0, "R3 sweep");
    chk("R8 sticky clear", int'(err_sticky), 0);
    // R5, R6 per bit
    for (int k = 0; k < W; k++) step(8'h6E, 8'h19, 1, 0, 0, k, "R5");
    for (int k = 0; k < W; k++) step(8'h24, 8'hF0, 0, 1, 0, k, "R6");
    step(8'h33, 8'h81, 0, 0, 1, 0, "R7");
    step(8'h00, 8'h00, 0, 0, 0, 0, "R8 clean after");
    chk("R8 sticky held", int'(err_sticky), 1);
    // reset clears the sticky flag, then a single prediction flip sets it
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    chk("R1 sticky after reset", int'(err_sticky), 0);
    step(8'h10, 8'h01, 0, 0, 1, 0, "R7 again");
    chk("R8 sticky not yet", int'(err_sticky), 0);
    step(8'h10, 8'h01, 0, 0, 0, 0, "R8");
    chk("R8 sticky set", int'(err_sticky), 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule